// File: doc/BRIEF.md
# Pipelined Integer Divider with Run-Time Width and Sign Mode

This block divides a numerator by a denominator and returns a full-width quotient and remainder. It accepts one operation on every clock cycle and returns each result a fixed number of cycles later, in issue order. A valid bit travels with every operation, so a caller that leaves gaps in its input stream sees the same gaps at the output.

For each operation the caller gives an operation code and a width code. The operation code picks signed or unsigned arithmetic. The width code says how many low-order bits of each operand count. Those bits are widened to 64 bits before the division starts: signed operations copy the top bit of the chosen width upward, and unsigned operations fill with zeros. Both results are always 64 bits wide, whatever the operand width.

The division runs as a restoring shift-subtract pipeline with one quotient bit per stage. It works on operand magnitudes. A final stage applies the signs and the divide-by-zero result.

Top module: `pipe_divider`

## Requirements
- R1: `in_op` = 2 selects signed division; `in_op` = 1, and every other value, selects unsigned division.
- R2: `in_width` 1, 2, 3 and 4 select 8, 16, 24 and 32-bit operands, and every other code selects 64-bit operands. Operand bits above the selected width have no effect on the result.
- R3: Unsigned division zero-extends both operands. It returns the floor quotient and a remainder that is smaller than the denominator (example: 8-bit 4 / 2 gives quotient 2, remainder 0).
- R4: Signed division sign-extends both operands from the top bit of the selected width. The quotient truncates toward zero. The remainder has the sign of the numerator, and both results are 64-bit two's complement.
- R5: A zero denominator, after extension, gives a quotient of all ones, a remainder equal to the extended numerator, and `out_dz` = 1. Every other operation returns `out_dz` = 0.
- R6: Each result appears with `out_valid` high exactly 65 rising edges after the edge that captured its `in_valid`. Results leave in issue order, and `out_valid` is never high without a matching input.
- R7: Operations can be issued on consecutive cycles with no stall, and each one produces its own result.
- R8: While `rst_n` is low, `out_valid` is 0, and no operation issued before the reset comes out afterwards.
- R9: Signed 64-bit -2^63 / -1 wraps to quotient 0x8000000000000000 with remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 8 | Operation code: 2 = signed, otherwise unsigned |
| in_width | input | 8 | Operand width code |
| in_num | input | 64 | Numerator |
| in_den | input | 64 | Denominator |
| out_valid | output | 1 | Result present this cycle |
| out_quot | output | 64 | Quotient |
| out_rem | output | 64 | Remainder |
| out_dz | output | 1 | Denominator was zero |

## Verification
Two cases are hard to reach from the ports. One is a signed operand whose sign bit sits inside a narrow width while the bits above that width hold garbage. The other is a full pipeline being flushed by reset. Random stimulus mixes every width code, including the undefined ones, with operation codes other than 1 and 2 and with denominators that are zero, all ones or very small. Directed cases cover the minimum-value signed overflow, and a reset is forced while the pipeline is full so that nothing issued earlier emerges afterwards.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int DW = 64;
  localparam int CW = 8;
  localparam logic [CW-1:0] OP_SIGNED = CW'(2);

  typedef logic [DW-1:0] word_t;

  typedef struct packed {
    logic  valid;
    logic  dz;
    logic  neg_q;
    logic  neg_r;
    word_t rem;
    word_t qn;
    word_t den;
  } lane_t;

  function automatic int unsigned width_of(logic [CW-1:0] code);
    case (code)
      CW'(1):  return 8;
      CW'(2):  return 16;
      CW'(3):  return 24;
      CW'(4):  return 32;
      default: return DW;
    endcase
  endfunction

  function automatic word_t extend(word_t v, int unsigned w, logic sgn);
    word_t mask;
    word_t r;
    mask = (w >= DW) ? '1 : ((word_t'(1) << w) - word_t'(1));
    r = v & mask;
    if (sgn && w < DW && v[w-1]) r = r | ~mask;
    return r;
  endfunction

  function automatic word_t magnitude(word_t v, logic neg);
    return neg ? (~v + word_t'(1)) : v;
  endfunction

  function automatic lane_t div_step(lane_t s);
    lane_t       o;
    logic [DW:0] trial;
    logic        qbit;
    o     = s;
    trial = {s.rem, s.qn[DW-1]};
    qbit  = (trial >= {1'b0, s.den});
    if (qbit) trial = trial - {1'b0, s.den};
    o.rem = trial[DW-1:0];
    o.qn  = {s.qn[DW-2:0], qbit};
    return o;
  endfunction
endpackage

// File: rtl/div_prep.sv
module div_prep
  import div_pkg::*;
(
  input  logic          valid_i,
  input  logic [CW-1:0] op_i,
  input  logic [CW-1:0] width_i,
  input  word_t         num_i,
  input  word_t         den_i,
  output lane_t         lane_o
);
  logic        sgn;
  int unsigned w;
  word_t       n_ext;
  word_t       d_ext;
  logic        n_neg;
  logic        d_neg;

  always_comb begin
    sgn   = (op_i == OP_SIGNED);
    w     = width_of(width_i);
    n_ext = extend(num_i, w, sgn);
    d_ext = extend(den_i, w, sgn);
    n_neg = sgn & n_ext[DW-1];
    d_neg = sgn & d_ext[DW-1];
    lane_o.valid = valid_i;
    lane_o.dz    = (d_ext == '0);
    lane_o.neg_q = n_neg ^ d_neg;
    lane_o.neg_r = n_neg;
    lane_o.rem   = '0;
    lane_o.qn    = magnitude(n_ext, n_neg);
    lane_o.den   = magnitude(d_ext, d_neg);
  end
endmodule

// File: rtl/div_stage.sv
module div_stage
  import div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  lane_t lane_i,
  output lane_t lane_o
);
  lane_t lane_q;
  lane_t step_w;

  assign step_w = div_step(lane_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else        lane_q <= step_w;
  end

  assign lane_o = lane_q;

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_q.valid && !lane_q.dz) |-> (lane_q.rem < lane_q.den)); // R3
endmodule

// File: rtl/div_fixup.sv
module div_fixup
  import div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  lane_t lane_i,
  output logic  valid_o,
  output word_t quot_o,
  output word_t rem_o,
  output logic  dz_o
);
  word_t q_fix;
  word_t r_fix;

  always_comb begin
    q_fix = lane_i.dz ? '1 : magnitude(lane_i.qn, lane_i.neg_q);
    r_fix = magnitude(lane_i.rem, lane_i.neg_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      quot_o  <= '0;
      rem_o   <= '0;
      dz_o    <= 1'b0;
    end else begin
      valid_o <= lane_i.valid;
      quot_o  <= q_fix;
      rem_o   <= r_fix;
      dz_o    <= lane_i.dz;
    end
  end

  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lane_i.valid) && $past(lane_i.neg_r) && rem_o != '0) |-> rem_o[DW-1]); // R4
endmodule

// File: rtl/pipe_divider.sv
module pipe_divider
  import div_pkg::*;
#(
  parameter int STAGES = div_pkg::DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_op,
  input  logic [7:0]    in_width,
  input  logic [63:0]   in_num,
  input  logic [63:0]   in_den,
  output logic          out_valid,
  output logic [63:0]   out_quot,
  output logic [63:0]   out_rem,
  output logic          out_dz
);
  localparam int LAT = STAGES + 1;
  localparam int OCC_W = $clog2(LAT + 2) + 1;

  lane_t chain [0:STAGES];

  div_prep u_prep (
    .valid_i (in_valid),
    .op_i    (in_op),
    .width_i (in_width),
    .num_i   (in_num),
    .den_i   (in_den),
    .lane_o  (chain[0])
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    div_stage u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .lane_i (chain[g]),
      .lane_o (chain[g+1])
    );
  end

  div_fixup u_fix (
    .clk     (clk),
    .rst_n   (rst_n),
    .lane_i  (chain[STAGES]),
    .valid_o (out_valid),
    .quot_o  (out_quot),
    .rem_o   (out_rem),
    .dz_o    (out_dz)
  );

  // Observation counters for the assertions below
  logic [OCC_W-1:0] in_flight;
  logic [OCC_W-1:0] since_rst;
  logic             w_enter;
  logic             w_leave;

  assign w_enter = in_valid;
  assign w_leave = out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_flight <= '0;
      since_rst <= '0;
    end else begin
      in_flight <= in_flight + OCC_W'(w_enter) - OCC_W'(w_leave);
      if (since_rst < OCC_W'(LAT)) since_rst <= since_rst + OCC_W'(1);
    end
  end

  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight <= OCC_W'(LAT)); // R6
  AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < OCC_W'(LAT)) |-> !out_valid); // R8
  AST_DZ_QUOT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dz) |-> (out_quot == '1)); // R5
  AST_NARROW_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op != 8'd2 && in_width == 8'd1) |-> ((chain[0].qn >> 8) == '0)); // R2
endmodule

// File: tb/test_pipe_divider.sv
`timescale 1ns/1ps
module test_pipe_divider;
  localparam int LAT = 65;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_op = '0;
  logic [7:0]  in_width = '0;
  logic [63:0] in_num = '0;
  logic [63:0] in_den = '0;
  logic        out_valid;
  logic [63:0] out_quot;
  logic [63:0] out_rem;
  logic        out_dz;

  always #4 clk = ~clk;

  pipe_divider i_pipe_divider (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_width(in_width), .in_num(in_num), .in_den(in_den),
    .out_valid(out_valid), .out_quot(out_quot), .out_rem(out_rem), .out_dz(out_dz)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [63:0] eq_q[$];
  logic [63:0] er_q[$];
  logic        ed_q[$];
  int          ec_q[$];
  string       et_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [63:0] widen(logic [63:0] v, logic [7:0] code, bit sg);
    int sh;
    case (code)
      8'd1: sh = 56; 8'd2: sh = 48; 8'd3: sh = 40; 8'd4: sh = 32;
      default: sh = 0;
    endcase
    if (sg) return 64'($signed(v << sh) >>> sh);
    return (v << sh) >> sh;
  endfunction

  // Reference model written from R1..R5 and R9
  task automatic model(input logic [7:0] op, input logic [7:0] code,
                       input logic [63:0] n, input logic [63:0] d,
                       output logic [63:0] q, output logic [63:0] r,
                       output logic dz, output string tag);
    bit sg;
    logic [63:0] ne, de;
    longint sn, sd;
    sg = (op == 8'd2);                     // R1
    ne = widen(n, code, sg);               // R2
    de = widen(d, code, sg);
    tag = sg ? "R1 R2 R4" : "R1 R2 R3";
    dz = (de == 64'd0);
    if (dz) begin
      q = '1; r = ne; tag = "R5";
    end else if (!sg) begin
      q = ne / de; r = ne % de;
    end else if (ne == 64'h8000_0000_0000_0000 && de == '1) begin
      q = ne; r = 64'd0; tag = "R9";
    end else begin
      sn = longint'(ne); sd = longint'(de);
      q = 64'(sn / sd); r = 64'(sn % sd);
    end
  endtask

  task automatic issue(logic [7:0] op, logic [7:0] code, logic [63:0] n, logic [63:0] d);
    logic [63:0] q, r;
    logic dz;
    string tag;
    @(negedge clk);
    model(op, code, n, d, q, r, dz, tag);
    in_valid = 1'b1; in_op = op; in_width = code; in_num = n; in_den = d;
    eq_q.push_back(q); er_q.push_back(r); ed_q.push_back(dz);
    ec_q.push_back(cyc); et_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_num = {$urandom(), $urandom()};
    end
  endtask

  // Output monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (eq_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected out_valid got 1 exp 0");
      end else begin
        automatic string t = et_q.pop_front();
        chk(t, "quot", out_quot, eq_q.pop_front());
        chk(t, "rem", out_rem, er_q.pop_front());
        chk(t, "dz", 64'(out_dz), 64'(ed_q.pop_front()));
        chk("R6", "latency", 64'(cyc - ec_q.pop_front()), 64'(LAT));
      end
    end
  end

  initial begin
    automatic int unsigned seed = $urandom(32'd4321);
    repeat (3) @(negedge clk);
    chk("R8", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;

    // directed corners
    issue(8'd1, 8'd1, 64'hDEAD_0000_0000_1204, 64'h5555_0000_0000_AB02); // R2 R3: 4/2
    issue(8'd2, 8'd1, 64'h0000_0000_0000_00FC, 64'h0000_0000_0000_0003); // R4: -4/3
    issue(8'd2, 8'd2, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_FFFF); // R4: -32768/-1
    issue(8'd2, 8'd5, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF); // R9
    issue(8'd2, 8'd3, 64'h0000_0000_0080_0007, 64'hFF00_0000_0000_0000); // R5 signed dz
    issue(8'd1, 8'd4, 64'h0000_0000_0000_0009, 64'h0000_0001_0000_0000); // R2 R5 high bits dropped
    issue(8'd0, 8'd0, 64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFFF); // R1 R2 code 0
    issue(8'd7, 8'd6, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0002); // R1 code 6
    issue(8'd2, 8'd255, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFD); // R4 code 255
    issue(8'd2, 8'd3, 64'h0000_0000_00FF_FFF9, 64'h0000_0000_0000_0002); // R4 24-bit -7/2
    idle(3);

    // random, mostly back to back (R7)
    for (int i = 0; i < 1500; i++) begin
      automatic logic [63:0] n = {$urandom(), $urandom()};
      automatic logic [63:0] d = {$urandom(), $urandom()};
      automatic int sel = $urandom_range(0, 15);
      if (sel == 0) d = 64'd0;
      else if (sel == 1) d = '1;
      else if (sel < 7) d = d >> $urandom_range(0, 63);
      if ($urandom_range(0, 9) == 0) idle(1);
      issue(8'($urandom_range(0, 3)), 8'($urandom_range(0, 7)), n, d);
    end
    idle(LAT + 5);
    chk("R6", "pending after drain", 64'(eq_q.size()), 64'd0);

    // reset flush with a full pipeline (R8)
    for (int i = 0; i < 40; i++)
      issue(8'd1, 8'd5, {$urandom(), $urandom()}, 64'd3);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    eq_q.delete(); er_q.delete(); ed_q.delete(); ec_q.delete(); et_q.delete();
    @(negedge clk);
    chk("R8", "out_valid during reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    idle(LAT + 5);
    issue(8'd1, 8'd1, 64'd4, 64'd2); // R3 example after reset
    idle(LAT + 3);
    chk("R6", "pending at end", 64'(eq_q.size()), 64'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule